// File: doc/BRIEF.md
# Multi-Stream Pacing Value Calculator

This block works out the pacing values that a multi-stream transport link needs for one stream. A controller presents the stream's pixel clock, bits per pixel, payload bandwidth number, the link rate and the lane count. It can also present two optional overhead factors, one for compression and one for forward error correction. It then pulses `start`. The block computes a lower and an upper estimate of the time-slot count and takes their midpoint. It applies the overhead factors, snaps the result to a grid of 1/(256·lanes) slot, and scales it by the lane count. The outputs are an integer symbol count and an 8-bit fraction in units of 1/256.

All intermediate values are unsigned 32.32 fixed point. The three divisions share one restoring shift-subtract divider that yields one quotient bit per cycle. The overhead factors go through a serial shift-add multiplier. A lane count or link rate of zero is reported as a divide-by-zero error and no arithmetic is done. Each run ends with a one-cycle `done` pulse, and the outputs then hold until the next accepted run.

Top module: `rg_pacing_calc`

## Requirements
- R1: The lower estimate is floor(pclk·bpp·8·2^32 / (link_rate·lanes)), in 32.32 fixed point.
- R2: When `comp_en` is 1, `comp_bpp` is used in place of `bpp` in the lower estimate. When `comp_en` is 0, `comp_bpp` has no effect.
- R3: The upper estimate is floor(pbn·54000·2^32 / (link_rate·lanes)). The target is floor((lower + upper) / 2).
- R4: A nonzero `dsc_ovh` multiplies the target first. A nonzero `fec_ovh` then multiplies the result. Each product is (a·b) >> 32, truncated to 64 bits. A factor of zero leaves the target unchanged. `raw_target` reports the target after both factors.
- R5: ts_int is bits 63:32 of the target. If bits 31:0 (the fraction f) are nonzero, ts_enum = floor(f·256·lanes / 2^32). If they are zero, ts_enum = 256·lanes, which makes `x_int` equal to (ts_int+1)·lanes.
- R6: The symbol value is s = (ts_int·2^32 + floor(ts_enum·2^32 / (256·lanes)))·lanes. `x_int` = s >> 32. `y_frac` = ceil((s mod 2^32) / 2^24), so a fraction that falls short of a whole 1/256 is rounded up.
- R7: If the rounded-up fraction reaches 256, `y_frac` is 0 and `x_int` is increased by one.
- R8: A `start` accepted with `lanes` = 0 or `link_rate` = 0 sets `err_div0`, sets `x_int`, `y_frac` and `raw_target` to zero, and pulses `done` in the next cycle. A good run clears `err_div0`.
- R9: `done` is high for exactly one cycle per run. `x_int`, `y_frac`, `raw_target` and `err_div0` change only in the cycle in which `done` is high.
- R10: All inputs are captured when `start` is accepted in the idle state. A `start` during a run, and any input change during a run, are ignored.
- R11: After reset `done` and `err_div0` are 0, and `x_int`, `y_frac` and `raw_target` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| pclk_khz | input | PCLK_W | Stream pixel clock |
| bpp | input | BPP_W | Uncompressed bits per pixel |
| comp_en | input | 1 | Use compressed bits per pixel |
| comp_bpp | input | BPP_W | Compressed bits per pixel |
| pbn | input | PBN_W | Payload bandwidth number |
| link_rate | input | LCLK_W | Per-lane link rate |
| lanes | input | LANES_W | Lane count |
| dsc_ovh | input | 64 | Compression overhead factor, 32.32, 0 = none |
| fec_ovh | input | 64 | FEC overhead factor, 32.32, 0 = none |
| done | output | 1 | One-cycle completion pulse |
| err_div0 | output | 1 | Last run had a zero lane count or link rate |
| x_int | output | 32 | Integer symbol count |
| y_frac | output | 8 | Fraction in 1/256 units |
| raw_target | output | 64 | Target slot count after overheads, 32.32 |

## Verification
Realistic stream and link mixes over one to seven lanes probe the two estimates and the midpoint against an independent wide-integer model. Vectors with one or both overhead factors, and with compression on, show the multiply order and the bpp selection. Hand-picked targets make the fraction exact, exactly zero, or just above a 1/(256·lanes) step at three lanes. These separate plain truncation from the round-up, the "no fraction adds a whole grid" rule and the carry into `x_int`. Zero lanes, zero link rate and a second `start` during a run, with the inputs changed mid-run, check the error path and input capture.

// File: rtl/rg_pkg.sv
package rg_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_MIN, S_MAX, S_DSC, S_DSC_W, S_FEC, S_FEC_W, S_QUANT, S_FRAC
  } rg_state_e;

  // Snap a 32-bit fraction onto the 1/(256*lanes) grid (R5).
  function automatic logic [15:0] rg_quant_enum(input logic [31:0] frac,
                                                input logic [7:0]  lanes);
    logic [15:0] grid;
    logic [47:0] prod;
    grid = {lanes, 8'h00};
    prod = 48'(frac) * 48'(grid);
    if (frac == 32'd0) return grid;
    return 16'(prod >> 32);
  endfunction

  // Scale by lanes, split into integer and rounded-up 1/256 fraction (R6, R7).
  function automatic logic [39:0] rg_finish(input logic [31:0] ts_int,
                                            input logic [63:0] frac_fx,
                                            input logic [7:0]  lanes);
    logic [71:0] sym;
    logic [31:0] xi;
    logic [31:0] ynum;
    logic [8:0]  yr;
    sym  = ({8'd0, ts_int, 32'd0} + {8'd0, frac_fx}) * 72'(lanes);
    xi   = 32'(sym >> 32);
    ynum = 32'(sym);
    yr   = {1'b0, ynum[31:24]} + {8'd0, |ynum[23:0]};
    if (yr[8]) return {xi + 32'd1, 8'd0};
    return {xi, yr[7:0]};
  endfunction

endpackage

// File: rtl/rg_serial_div.sv
module rg_serial_div #(
  parameter int Q_W = 64,
  parameter int D_W = 27
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [Q_W-1:0] dividend,
  input  logic [D_W-1:0] divisor,
  output logic           done,
  output logic [Q_W-1:0] quotient
);
  localparam int CNT_W = $clog2(Q_W);

  logic [Q_W-1:0]   dvd;
  logic [D_W-1:0]   dsr;
  logic [D_W-1:0]   rem;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic [D_W:0]     rem_sh;
  logic             fits;
  logic [D_W:0]     rem_nx;

  always_comb begin
    rem_sh = {rem, dvd[Q_W-1]};
    fits   = rem_sh >= {1'b0, dsr};
    rem_nx = fits ? (rem_sh - {1'b0, dsr}) : rem_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd <= '0; dsr <= '0; rem <= '0; cnt <= '0;
      run <= 1'b0; done <= 1'b0; quotient <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        dvd <= dividend; dsr <= divisor; rem <= '0;
        cnt <= '0; quotient <= '0; run <= 1'b1;
      end else if (run) begin
        rem      <= rem_nx[D_W-1:0];
        dvd      <= dvd << 1;
        quotient <= {quotient[Q_W-2:0], fits};
        cnt      <= cnt + 1'b1;
        if (cnt == CNT_W'(Q_W - 1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rg_serial_mul.sv
module rg_serial_mul #(
  parameter int W    = 64,
  parameter int FRAC = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         done,
  output logic [W-1:0] prod
);
  localparam int CNT_W = $clog2(W);

  logic [2*W-1:0]   mcand;
  logic [2*W-1:0]   acc;
  logic [W-1:0]     mplier;
  logic [CNT_W-1:0] cnt;
  logic             run;

  assign prod = W'(acc >> FRAC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand <= '0; acc <= '0; mplier <= '0; cnt <= '0;
      run <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        mcand <= {{W{1'b0}}, a}; mplier <= b; acc <= '0;
        cnt <= '0; run <= 1'b1;
      end else if (run) begin
        if (mplier[0]) acc <= acc + mcand;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        cnt    <= cnt + 1'b1;
        if (cnt == CNT_W'(W - 1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rg_pacing_calc.sv
module rg_pacing_calc
  import rg_pkg::*;
#(
  parameter int PCLK_W  = 20,
  parameter int BPP_W   = 8,
  parameter int PBN_W   = 16,
  parameter int LCLK_W  = 24,
  parameter int LANES_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [PCLK_W-1:0]  pclk_khz,
  input  logic [BPP_W-1:0]   bpp,
  input  logic               comp_en,
  input  logic [BPP_W-1:0]   comp_bpp,
  input  logic [PBN_W-1:0]   pbn,
  input  logic [LCLK_W-1:0]  link_rate,
  input  logic [LANES_W-1:0] lanes,
  input  logic [63:0]        dsc_ovh,
  input  logic [63:0]        fec_ovh,
  output logic               done,
  output logic               err_div0,
  output logic [31:0]        x_int,
  output logic [7:0]         y_frac,
  output logic [63:0]        raw_target
);
  localparam int FX_W   = 64;
  localparam int DEN_W  = LCLK_W + LANES_W;
  localparam int GRID_W = 8 + LANES_W;
  localparam int DIV_W  = (DEN_W > GRID_W) ? DEN_W : GRID_W;

  rg_state_e state;

  logic [LANES_W-1:0] lanes_q;
  logic [DIV_W-1:0]   den_q;
  logic [PBN_W-1:0]   pbn_q;
  logic [FX_W-1:0]    dsc_q, fec_q;
  logic [FX_W-1:0]    min_fx;
  logic [FX_W-1:0]    acc;

  logic               div_go, div_done;
  logic [FX_W-1:0]    div_dvd, div_q;
  logic [DIV_W-1:0]   div_dsr;
  logic               mul_go, mul_done;
  logic [FX_W-1:0]    mul_b, mul_p;

  // Named internal events for the checker
  logic               busy;
  logic               accept;
  logic               zero_div;

  logic [BPP_W-1:0]   bpp_sel;
  logic [31:0]        min_num, max_num;
  logic [DIV_W-1:0]   den_in, grid;
  logic [FX_W:0]      pair_sum;
  logic [15:0]        ts_enum;
  logic [39:0]        fin;
  logic [7:0]         lanes8;

  assign busy     = (state != S_IDLE);
  assign accept   = start && !busy;
  assign zero_div = (lanes == '0) || (link_rate == '0);
  assign lanes8   = 8'(lanes_q);

  always_comb begin
    bpp_sel  = comp_en ? comp_bpp : bpp;
    min_num  = 32'(pclk_khz) * 32'(bpp_sel) * 32'd8;
    max_num  = 32'(pbn_q) * 32'd54000;
    den_in   = DIV_W'(link_rate) * DIV_W'(lanes);
    grid     = DIV_W'({lanes_q, 8'h00});
    pair_sum = {1'b0, min_fx} + {1'b0, div_q};
    ts_enum  = rg_quant_enum(acc[31:0], lanes8);
    fin      = rg_finish(acc[63:32], div_q, lanes8);
    mul_b    = (state == S_FEC_W) ? fec_q : dsc_q;
  end

  rg_serial_div #(.Q_W(FX_W), .D_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .dividend(div_dvd),
    .divisor(div_dsr), .done(div_done), .quotient(div_q)
  );

  rg_serial_mul #(.W(FX_W), .FRAC(FX_W/2)) u_mul (
    .clk(clk), .rst_n(rst_n), .go(mul_go), .a(acc), .b(mul_b),
    .done(mul_done), .prod(mul_p)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      lanes_q <= '0; den_q <= '0; pbn_q <= '0; dsc_q <= '0; fec_q <= '0;
      min_fx <= '0; acc <= '0;
      div_go <= 1'b0; div_dvd <= '0; div_dsr <= '0; mul_go <= 1'b0;
      done <= 1'b0; err_div0 <= 1'b0;
      x_int <= '0; y_frac <= '0; raw_target <= '0;
    end else begin
      div_go <= 1'b0;
      mul_go <= 1'b0;
      done   <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          lanes_q <= lanes; den_q <= den_in; pbn_q <= pbn;
          dsc_q <= dsc_ovh; fec_q <= fec_ovh;
          if (zero_div) begin
            err_div0 <= 1'b1; done <= 1'b1;
            x_int <= '0; y_frac <= '0; raw_target <= '0;
          end else begin
            div_dvd <= {min_num, 32'd0};
            div_dsr <= den_in;
            div_go  <= 1'b1;
            state   <= S_MIN;
          end
        end
        S_MIN: if (div_done) begin
          min_fx  <= div_q;
          div_dvd <= {max_num, 32'd0};
          div_dsr <= den_q;
          div_go  <= 1'b1;
          state   <= S_MAX;
        end
        S_MAX: if (div_done) begin
          acc   <= FX_W'(pair_sum >> 1);
          state <= S_DSC;
        end
        S_DSC: begin
          mul_go <= (dsc_q != '0);
          state  <= (dsc_q != '0) ? S_DSC_W : S_FEC;
        end
        S_DSC_W: if (mul_done) begin
          acc   <= mul_p;
          state <= S_FEC;
        end
        S_FEC: begin
          mul_go <= (fec_q != '0);
          state  <= (fec_q != '0) ? S_FEC_W : S_QUANT;
        end
        S_FEC_W: if (mul_done) begin
          acc   <= mul_p;
          state <= S_QUANT;
        end
        S_QUANT: begin
          div_dvd <= {16'd0, ts_enum, 32'd0};
          div_dsr <= grid;
          div_go  <= 1'b1;
          state   <= S_FRAC;
        end
        S_FRAC: if (div_done) begin
          x_int      <= fin[39:8];
          y_frac     <= fin[7:0];
          raw_target <= acc;
          err_div0   <= 1'b0;
          done       <= 1'b1;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rg_pacing_chk.sv
module rg_pacing_chk #(
  parameter int LANES_W = 3,
  parameter int LCLK_W  = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [LANES_W-1:0] lanes,
  input logic [LCLK_W-1:0]  link_rate,
  input logic               done,
  input logic               err_div0,
  input logic [31:0]        x_int,
  input logic [7:0]         y_frac,
  input logic [63:0]        raw_target,
  input logic               busy,
  input logic [LANES_W-1:0] lanes_q
);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(x_int) && $stable(y_frac) && $stable(raw_target)
               && $stable(err_div0)));

  assert_zero_divisor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (lanes == '0 || link_rate == '0))
      |=> (done && err_div0 && x_int == 32'd0 && y_frac == 8'd0
           && raw_target == 64'd0));

  assert_capture_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(lanes_q));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !done);
endmodule

bind rg_pacing_calc rg_pacing_chk #(.LANES_W(LANES_W), .LCLK_W(LCLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .lanes(lanes),
  .link_rate(link_rate), .done(done), .err_div0(err_div0), .x_int(x_int),
  .y_frac(y_frac), .raw_target(raw_target), .busy(busy), .lanes_q(lanes_q)
);

// File: tb/sim_rg_pacing_calc.sv
module sim_rg_pacing_calc;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, start, comp_en, done, err_div0;
  logic [19:0] pclk_khz;
  logic [7:0]  bpp, comp_bpp, y_frac;
  logic [15:0] pbn;
  logic [23:0] link_rate;
  logic [2:0]  lanes;
  logic [63:0] dsc_ovh, fec_ovh, raw_target;
  logic [31:0] x_int;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct packed {
    logic [19:0] pclk; logic [7:0] bpp; logic ce; logic [7:0] cbpp;
    logic [15:0] pbn; logic [23:0] lclk; logic [2:0] ln;
    logic [63:0] dsc; logic [63:0] fec;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{20'd148500, 8'd24, 1'b0, 8'd0,  16'd532,  24'd270000, 3'd4, 64'd0, 64'd0},
    '{20'd297000, 8'd30, 1'b0, 8'd0,  16'd1200, 24'd540000, 3'd4, 64'd0, 64'd0},
    '{20'd148500, 8'd24, 1'b1, 8'd12, 16'd300,  24'd270000, 3'd2, 64'd0, 64'h1_0A3D_70A4},
    '{20'd25175,  8'd18, 1'b0, 8'd0,  16'd60,   24'd162000, 3'd1, 64'h1_1EB8_51EC, 64'h1_0A3D_70A4},
    '{20'd533250, 8'd24, 1'b0, 8'd0,  16'd2400, 24'd810000, 3'd3, 64'd0, 64'd0},
    '{20'd74250,  8'd24, 1'b0, 8'd0,  16'd270,  24'd270000, 3'd5, 64'h1_0800_0000, 64'd0},
    '{20'd1000,   8'd8,  1'b0, 8'd0,  16'd1,    24'd1,      3'd7, 64'd0, 64'd0},
    '{20'd3375,   8'd8,  1'b0, 8'd0,  16'd6,    24'd27000,  3'd4, 64'd0, 64'd0}
  };

  // Wide-integer model of the requirements
  task automatic model(input vec_t v, output logic [31:0] ex, output logic [7:0] ey,
                       output logic [63:0] er, output logic eerr);
    logic [127:0] den, bp, mn, mx, raw, ti, fr, g, te, fq, sym, yn, yc, xr;
    den = 128'(v.lclk) * 128'(v.ln);
    if (den == 0) begin
      ex = 0; ey = 0; er = 0; eerr = 1'b1;
      return;
    end
    bp  = v.ce ? 128'(v.cbpp) : 128'(v.bpp);
    mn  = ((128'(v.pclk) * bp * 128'd8) << 32) / den;
    mx  = ((128'(v.pbn) * 128'd54000) << 32) / den;
    raw = (mn + mx) / 2;
    if (v.dsc != 0) raw = 128'(64'((raw * 128'(v.dsc)) >> 32));
    if (v.fec != 0) raw = 128'(64'((raw * 128'(v.fec)) >> 32));
    ti  = raw >> 32;
    fr  = raw % (128'd1 << 32);
    g   = 128'd256 * 128'(v.ln);
    te  = (fr != 0) ? ((fr * g) >> 32) : g;
    fq  = (te << 32) / g;
    sym = ((ti << 32) + fq) * 128'(v.ln);
    xr  = sym >> 32;
    yn  = sym % (128'd1 << 32);
    yc  = (yn + 128'd16777215) / 128'd16777216;
    if (yc == 256) begin xr = xr + 1; yc = 0; end
    ex = 32'(xr); ey = 8'(yc); er = 64'(raw); eerr = 1'b0;
  endtask

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    pclk_khz = v.pclk; bpp = v.bpp; comp_en = v.ce; comp_bpp = v.cbpp;
    pbn = v.pbn; link_rate = v.lclk; lanes = v.ln; dsc_ovh = v.dsc; fec_ovh = v.fec;
  endtask

  task automatic wait_done(input string req);
    int w = 0;
    while (!done && w < 3000) begin
      @(negedge clk);
      w++;
    end
    if (w >= 3000) begin
      n_tests++; n_fail++;
      $display("FAIL %s watchdog: actual=no done expected=done", req);
    end
  endtask

  task automatic run(input vec_t v, input string req);
    @(negedge clk);
    drive(v); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(req);
  endtask

  task automatic check_all(input string req, input logic [31:0] ex,
                           input logic [7:0] ey, input logic [63:0] er, input logic ee);
    check(req, "x_int", 64'(x_int), 64'(ex));
    check(req, "y_frac", 64'(y_frac), 64'(ey));
    check(req, "raw_target", raw_target, er);
    check(req, "err_div0", 64'(err_div0), 64'(ee));
  endtask

  rg_pacing_calc u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pclk_khz(pclk_khz), .bpp(bpp),
    .comp_en(comp_en), .comp_bpp(comp_bpp), .pbn(pbn), .link_rate(link_rate),
    .lanes(lanes), .dsc_ovh(dsc_ovh), .fec_ovh(fec_ovh), .done(done),
    .err_div0(err_div0), .x_int(x_int), .y_frac(y_frac), .raw_target(raw_target)
  );

  initial begin
    #(4 * 150000);
    n_tests++; n_fail++;
    $display("FAIL global watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] ex; logic [7:0] ey; logic [63:0] er; logic ee;
    vec_t v;
    rst_n = 1'b0; start = 1'b0;
    drive(VECS[0]);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11", "done", 64'(done), 64'd0);
    check_all("R11", 32'd0, 8'd0, 64'd0, 1'b0);

    // Table walk: R1 R3 R4 R6 with R2 in vector 2
    for (int i = 0; i < NV; i++) begin
      run(VECS[i], "R1");
      model(VECS[i], ex, ey, er, ee);
      check_all($sformatf("R1/R3/R4/R6 vec%0d", i), ex, ey, er, ee);
      @(negedge clk);
      check("R9", "done pulse width", 64'(done), 64'd0);
    end

    // R3 midpoint, exact half fraction: expect 10 + 0/256, target 2.5
    v = '{20'd3375, 8'd8, 1'b0, 8'd0, 16'd6, 24'd27000, 3'd4, 64'd0, 64'd0};
    run(v, "R3");
    check_all("R3", 32'd10, 8'd0, 64'h2_8000_0000, 1'b0);

    // R2: bpp 16 would double lower estimate; compressed bpp 8 gives the same as above
    v = '{20'd3375, 8'd16, 1'b1, 8'd8, 16'd6, 24'd27000, 3'd4, 64'd0, 64'd0};
    run(v, "R2");
    check_all("R2", 32'd10, 8'd0, 64'h2_8000_0000, 1'b0);
    // R2: comp_bpp ignored when comp_en=0
    v = '{20'd3375, 8'd8, 1'b0, 8'd99, 16'd6, 24'd27000, 3'd4, 64'd0, 64'd0};
    run(v, "R2");
    check_all("R2", 32'd10, 8'd0, 64'h2_8000_0000, 1'b0);

    // R5: integer target 2.0 on 4 lanes gives (2+1)*4
    v = '{20'd3375, 8'd8, 1'b0, 8'd0, 16'd4, 24'd27000, 3'd4, 64'd0, 64'd0};
    run(v, "R5");
    check_all("R5", 32'd12, 8'd0, 64'h2_0000_0000, 1'b0);

    // R6: one lane, target 1.25 -> 1 + 64/256
    v = '{20'd0, 8'd8, 1'b0, 8'd0, 16'd1, 24'd21600, 3'd1, 64'd0, 64'd0};
    run(v, "R6");
    check_all("R6", 32'd1, 8'd64, 64'h1_4000_0000, 1'b0);

    // R6 round-up, three lanes: truncated fraction 99.99 rounds to 100; R4 dsc multiply
    v = '{20'd0, 8'd8, 1'b0, 8'd0, 16'd3, 24'd27000, 3'd3, 64'h1_2180_0000, 64'd0};
    run(v, "R6");
    check_all("R6/R4", 32'd3, 8'd100, 64'h1_2180_0000, 1'b0);

    // R7 carry: fraction rounds to 256 -> x+1, y=0
    v = '{20'd0, 8'd8, 1'b0, 8'd0, 16'd3, 24'd27000, 3'd3, 64'h1_5555_5556, 64'd0};
    run(v, "R7");
    check_all("R7", 32'd4, 8'd0, 64'h1_5555_5556, 1'b0);

    // R4: fec alone on target 1.0 (factor 1.5) gives raw 1.5
    v = '{20'd0, 8'd8, 1'b0, 8'd0, 16'd3, 24'd27000, 3'd3, 64'd0, 64'h1_8000_0000};
    run(v, "R4");
    model(v, ex, ey, er, ee);
    check("R4", "raw_target fec", raw_target, 64'h1_8000_0000);
    check_all("R4", ex, ey, er, ee);

    // R8: zero lanes, then zero link rate; done on the next cycle
    v = '{20'd3375, 8'd8, 1'b0, 8'd0, 16'd6, 24'd27000, 3'd0, 64'd0, 64'd0};
    @(negedge clk); drive(v); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R8", "done next cycle", 64'(done), 64'd1);
    check_all("R8", 32'd0, 8'd0, 64'd0, 1'b1);
    v = '{20'd3375, 8'd8, 1'b0, 8'd0, 16'd6, 24'd0, 3'd4, 64'd0, 64'd0};
    run(v, "R8");
    check_all("R8", 32'd0, 8'd0, 64'd0, 1'b1);
    // R8: a good run clears the error
    run(VECS[7], "R8");
    check("R8", "err cleared", 64'(err_div0), 64'd0);

    // R10: inputs changed and a second start during the run are ignored
    @(negedge clk); drive(VECS[0]); start = 1'b1;
    @(negedge clk); start = 1'b0; drive(VECS[1]);
    repeat (20) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done("R10");
    model(VECS[0], ex, ey, er, ee);
    check_all("R10", ex, ey, er, ee);
    // R9: outputs hold afterwards
    repeat (6) @(negedge clk);
    check("R9", "done low", 64'(done), 64'd0);
    check_all("R9 hold", ex, ey, er, ee);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule